// File: doc/BRIEF.md
# Aggregated interrupt vector controller

The block gathers interrupt sources arranged in groups of up to 31 and presents a single request, a vector and a requested priority level to a processor that takes external vectors. Each source has a sticky pending bit, an enable bit and a 2-bit priority code. Each group has one programmable 17-bit vector offset. In aggregated operation, any enabled pending source in a group makes the whole group request service with that group's single offset. The bit position that fired does not change the vector.

Within a group, the group priority is the highest code among its enabled pending sources. A cross-group encoder picks the group with the highest priority, and ties go to the lowest group index. The index runs from 0 upward and stands for the first group number onward. The encoder forms the vector and a level equal to the stored code plus one. Software uses a write-and-read register port to clear pending bits, set and clear enables, and program priorities and vector offsets.

Top module: `aivc_top`

## Requirements
- R1: After reset, irq_req, irq_level and irq_vector are 0, and every group register reads 0.
- R2: A pending bit is set in any clock where its src_evt bit is high, and it stays set until software clears it. Writing ones to selector 0 clears the pending bits at those positions. If an event and a clear hit the same bit in the same clock, the bit stays set.
- R3: Writing to selector 1 sets the enables at the one bits. Writing to selector 2 clears the enables at the one bits. Zero bits leave enables unchanged. Reading either selector returns the enables.
- R4: Sources occupy bit positions 0 to 30. Bit 31 of the pending and enable registers always reads 0.
- R5: When group g wins, irq_vector equals the 17-bit offset written to selector 3 (wdata[16:0]) of group g, whichever of its bits is pending.
- R6: irq_level equals the winning group's priority code plus one. A group's code is the highest among its enabled pending sources. Selector 4 holds the codes of sources 0 to 15 at bits 2i+1:2i. Selector 5 holds the codes of sources 16 to 30 at bits 2(i-16)+1:2(i-16).
- R7: Across groups, the highest code wins, and an equal code goes to the lower group index.
- R8: irq_req is 1 exactly when some enabled pending source exists. Otherwise irq_level and irq_vector are 0.
- R9: The outputs are registered. A state change made at clock edge k shows on the outputs after edge k+1.
- R10: A pending source that is not enabled raises no request. Enabling it later raises the request, because the pending bit is kept.
- R11: The register address is {group index, selector[2:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_evt | input | NUM_GRP*SRC_N | Source event lines, group g at bits g*SRC_N upward |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | GIDX_W+3 | Group index and register selector |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | VEC_W | Vector offset of the winning group |
| irq_level | output | PRIO_W+1 | Requested priority level |

## Verification
Two functions can fall in the same clock: a source event that sets a pending bit, and a software write-one-to-clear on that same bit. The bench provokes this on purpose by driving both in one clock, and the random phase also produces it. The judgement is that the bit reads back set and the request stays up. A second overlap is between arbitration and a priority or enable write that changes the winner. In that case the bench checks that the old winner stays on the outputs for exactly one more clock.

// File: rtl/aivc_pkg.sv
package aivc_pkg;
  localparam int REG_W = 32;

  // Register selector, low three address bits
  typedef enum logic [2:0] {
    SEL_PEND  = 3'd0,
    SEL_ENSET = 3'd1,
    SEL_ENCLR = 3'd2,
    SEL_VEC   = 3'd3,
    SEL_PRLO  = 3'd4,
    SEL_PRHI  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/aivc_group_regs.sv
module aivc_group_regs
  import aivc_pkg::*;
#(
  parameter int SRC_N  = 31,
  parameter int VEC_W  = 17,
  parameter int PRIO_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SRC_N-1:0]        evt,
  input  logic                    wr_hit,
  input  logic [2:0]              sel,
  input  logic [REG_W-1:0]        wdata,
  output logic [SRC_N-1:0]        pend_o,
  output logic [SRC_N-1:0]        en_o,
  output logic [SRC_N*PRIO_W-1:0] prio_o,
  output logic [VEC_W-1:0]        vec_o,
  output logic [REG_W-1:0]        rdata
);
  localparam int PER_WORD = REG_W / PRIO_W;

  logic [SRC_N-1:0]        pend_q, pend_d, en_q, en_d;
  logic [SRC_N*PRIO_W-1:0] prio_q, prio_d;
  logic [VEC_W-1:0]        vec_q, vec_d;
  logic                    pend_ce, en_ce, prio_ce, vec_ce;
  logic                    wr_pend, wr_enset, wr_enclr, wr_lo, wr_hi;

  assign wr_pend  = wr_hit && (sel == SEL_PEND);
  assign wr_enset = wr_hit && (sel == SEL_ENSET);
  assign wr_enclr = wr_hit && (sel == SEL_ENCLR);
  assign wr_lo    = wr_hit && (sel == SEL_PRLO);
  assign wr_hi    = wr_hit && (sel == SEL_PRHI);

  // Next state: the event set is applied after the clear, so a set wins
  always_comb begin
    pend_d = pend_q;
    if (wr_pend) pend_d = pend_q & ~wdata[SRC_N-1:0];
    pend_d  = pend_d | evt;
    pend_ce = wr_pend | (|evt);

    en_d = en_q;
    if (wr_enset) en_d = en_q | wdata[SRC_N-1:0];
    if (wr_enclr) en_d = en_q & ~wdata[SRC_N-1:0];
    en_ce = wr_enset | wr_enclr;

    vec_d  = wdata[VEC_W-1:0];
    vec_ce = wr_hit && (sel == SEL_VEC);

    prio_d = prio_q;
    for (int i = 0; i < SRC_N; i++) begin
      if ((i < PER_WORD) ? wr_lo : wr_hi)
        prio_d[i*PRIO_W +: PRIO_W] = wdata[(i % PER_WORD)*PRIO_W +: PRIO_W];
    end
    prio_ce = wr_lo | wr_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      prio_q <= '0;
      vec_q  <= '0;
    end else begin
      if (pend_ce) pend_q <= pend_d;
      if (en_ce)   en_q   <= en_d;
      if (prio_ce) prio_q <= prio_d;
      if (vec_ce)  vec_q  <= vec_d;
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    case (sel)
      SEL_PEND:            rdata[SRC_N-1:0] = pend_q;
      SEL_ENSET, SEL_ENCLR: rdata[SRC_N-1:0] = en_q;
      SEL_VEC:             rdata[VEC_W-1:0] = vec_q;
      SEL_PRLO, SEL_PRHI: begin
        for (int i = 0; i < SRC_N; i++) begin
          if ((i < PER_WORD) == (sel == SEL_PRLO))
            rdata[(i % PER_WORD)*PRIO_W +: PRIO_W] = prio_q[i*PRIO_W +: PRIO_W];
        end
      end
      default: rdata = '0;
    endcase
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign prio_o = prio_q;
  assign vec_o  = vec_q;
endmodule

// File: rtl/aivc_group_eval.sv
module aivc_group_eval #(
  parameter int SRC_N  = 31,
  parameter int PRIO_W = 2
) (
  input  logic [SRC_N-1:0]        pend,
  input  logic [SRC_N-1:0]        en,
  input  logic [SRC_N*PRIO_W-1:0] prio,
  output logic                    act,
  output logic [PRIO_W-1:0]       best
);
  always_comb begin
    act  = 1'b0;
    best = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (pend[i] && en[i]) begin
        if (!act || (prio[i*PRIO_W +: PRIO_W] > best))
          best = prio[i*PRIO_W +: PRIO_W];
        act = 1'b1;
      end
    end
  end
endmodule

// File: rtl/aivc_arbiter.sv
module aivc_arbiter #(
  parameter int NUM_GRP = 4,
  parameter int VEC_W   = 17,
  parameter int PRIO_W  = 2
) (
  input  logic [NUM_GRP-1:0]        act,
  input  logic [NUM_GRP*PRIO_W-1:0] best,
  input  logic [NUM_GRP*VEC_W-1:0]  vec,
  output logic                      any,
  output logic [PRIO_W-1:0]         code,
  output logic [VEC_W-1:0]          win_vec
);
  // Strict greater-than keeps the lowest index on a tie
  always_comb begin
    any     = 1'b0;
    code    = '0;
    win_vec = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (act[g] && (!any || (best[g*PRIO_W +: PRIO_W] > code))) begin
        any     = 1'b1;
        code    = best[g*PRIO_W +: PRIO_W];
        win_vec = vec[g*VEC_W +: VEC_W];
      end
    end
  end
endmodule

// File: rtl/aivc_top.sv
module aivc_top
  import aivc_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int SRC_N   = 31,
  parameter int VEC_W   = 17,
  parameter int PRIO_W  = 2,
  localparam int GIDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int ADDR_W = GIDX_W + 3,
  localparam int LVL_W  = PRIO_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_GRP*SRC_N-1:0] src_evt,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  output logic                     irq_req,
  output logic [VEC_W-1:0]         irq_vector,
  output logic [LVL_W-1:0]         irq_level
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic [GIDX_W-1:0] grp_idx;
  logic [2:0]        sel;
  assign grp_idx = reg_addr[ADDR_W-1:3];
  assign sel     = reg_addr[2:0];

  logic [NUM_GRP*SRC_N-1:0]        pend_flat, en_flat;
  logic [NUM_GRP*SRC_N*PRIO_W-1:0] prio_flat;
  logic [NUM_GRP*VEC_W-1:0]        vec_flat;
  logic [NUM_GRP-1:0]              grp_act;
  logic [NUM_GRP*PRIO_W-1:0]       grp_best;
  logic [REG_W-1:0]                rd_arr [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    assign hit = reg_wr && (grp_idx == GIDX_W'(g));

    aivc_group_regs #(.SRC_N(SRC_N), .VEC_W(VEC_W), .PRIO_W(PRIO_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .evt    (src_evt[g*SRC_N +: SRC_N]),
      .wr_hit (hit),
      .sel    (sel),
      .wdata  (reg_wdata),
      .pend_o (pend_flat[g*SRC_N +: SRC_N]),
      .en_o   (en_flat[g*SRC_N +: SRC_N]),
      .prio_o (prio_flat[g*SRC_N*PRIO_W +: SRC_N*PRIO_W]),
      .vec_o  (vec_flat[g*VEC_W +: VEC_W]),
      .rdata  (rd_arr[g])
    );

    aivc_group_eval #(.SRC_N(SRC_N), .PRIO_W(PRIO_W)) u_eval (
      .pend (pend_flat[g*SRC_N +: SRC_N]),
      .en   (en_flat[g*SRC_N +: SRC_N]),
      .prio (prio_flat[g*SRC_N*PRIO_W +: SRC_N*PRIO_W]),
      .act  (grp_act[g]),
      .best (grp_best[g*PRIO_W +: PRIO_W])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (grp_idx == GIDX_W'(g)) reg_rdata = rd_arr[g];
    end
  end

  logic              arb_any;
  logic [PRIO_W-1:0] arb_code;
  logic [VEC_W-1:0]  arb_vec;

  aivc_arbiter #(.NUM_GRP(NUM_GRP), .VEC_W(VEC_W), .PRIO_W(PRIO_W)) u_arb (
    .act     (grp_act),
    .best    (grp_best),
    .vec     (vec_flat),
    .any     (arb_any),
    .code    (arb_code),
    .win_vec (arb_vec)
  );

  // Output stage
  logic             req_d;
  logic [LVL_W-1:0] lvl_d;
  logic [VEC_W-1:0] vec_d;
  logic             out_ce;

  always_comb begin
    req_d  = arb_any;
    lvl_d  = arb_any ? ({1'b0, arb_code} + LVL_W'(1)) : '0;
    vec_d  = arb_any ? arb_vec : '0;
    out_ce = (req_d != irq_req) || (lvl_d != irq_level) || (vec_d != irq_vector);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_req    <= 1'b0;
      irq_level  <= '0;
      irq_vector <= '0;
    end else if (out_ce) begin
      irq_req    <= req_d;
      irq_level  <= lvl_d;
      irq_vector <= vec_d;
    end
  end
endmodule

// File: rtl/aivc_checker.sv
module aivc_checker
  import aivc_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int SRC_N   = 31,
  parameter int VEC_W   = 17,
  parameter int LVL_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic [2:0]               sel,
  input logic [REG_W-1:0]         reg_rdata,
  input logic                     irq_req,
  input logic [VEC_W-1:0]         irq_vector,
  input logic [LVL_W-1:0]         irq_level,
  input logic                     arb_any,
  input logic [NUM_GRP*SRC_N-1:0] pend_flat,
  input logic [NUM_GRP*SRC_N-1:0] en_flat
);
  assert_req_matches_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (irq_level != '0));

  assert_idle_vector_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vector == '0));

  assert_req_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arb_any |=> irq_req);

  assert_req_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_any |=> !irq_req);

  assert_pend_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (sel == SEL_PEND)) |=> ((pend_flat & $past(pend_flat)) == $past(pend_flat)));

  assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && ((sel == SEL_ENSET) || (sel == SEL_ENCLR))) |=> $stable(en_flat));

  assert_bit31_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == SEL_PEND) || (sel == SEL_ENSET) || (sel == SEL_ENCLR)) |-> !reg_rdata[31]);
endmodule

bind aivc_top aivc_checker #(
  .NUM_GRP (NUM_GRP),
  .SRC_N   (SRC_N),
  .VEC_W   (VEC_W),
  .LVL_W   (LVL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_wr     (reg_wr),
  .sel        (reg_addr[2:0]),
  .reg_rdata  (reg_rdata),
  .irq_req    (irq_req),
  .irq_vector (irq_vector),
  .irq_level  (irq_level),
  .arb_any    (arb_any),
  .pend_flat  (pend_flat),
  .en_flat    (en_flat)
);

// File: tb/aivc_top_test.sv
module aivc_top_test;
  localparam int NG = 4;
  localparam int SN = 31;
  localparam int VW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NG*SN-1:0] src_evt;
  logic          reg_wr;
  logic [4:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic          irq_req;
  logic [VW-1:0] irq_vector;
  logic [2:0]    irq_level;

  always #10 clk = ~clk;  // 50 MHz

  aivc_top uut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_vector(irq_vector), .irq_level(irq_level)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Shadow state built from the requirements
  logic [SN-1:0]   m_pend [NG];
  logic [SN-1:0]   m_en   [NG];
  logic [1:0]      m_prio [NG][SN];
  logic [VW-1:0]   m_vec  [NG];
  logic            e_req;
  logic [2:0]      e_lvl;
  logic [VW-1:0]   e_vec;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model_out(output logic rq, output logic [2:0] lv, output logic [VW-1:0] vc);
    logic found = 0;
    logic [1:0] bc = 0;
    rq = 0; lv = 0; vc = 0;
    for (int g = 0; g < NG; g++) begin
      logic ga = 0;
      logic [1:0] gb = 0;
      for (int i = 0; i < SN; i++)
        if (m_pend[g][i] && m_en[g][i]) begin
          if (!ga || m_prio[g][i] > gb) gb = m_prio[g][i];
          ga = 1;
        end
      if (ga && (!found || gb > bc)) begin
        found = 1; bc = gb; vc = m_vec[g];
      end
    end
    if (found) begin rq = 1; lv = {1'b0, bc} + 3'd1; end
  endfunction

  function automatic void model_step();
    int g = int'(reg_addr[4:3]);
    logic [2:0] s = reg_addr[2:0];
    if (reg_wr) begin
      case (s)
        3'd0: m_pend[g] = m_pend[g] & ~reg_wdata[SN-1:0];
        3'd1: m_en[g]   = m_en[g] | reg_wdata[SN-1:0];
        3'd2: m_en[g]   = m_en[g] & ~reg_wdata[SN-1:0];
        3'd3: m_vec[g]  = reg_wdata[VW-1:0];
        3'd4: for (int i = 0; i < 16; i++) m_prio[g][i] = reg_wdata[2*i +: 2];
        3'd5: for (int i = 16; i < SN; i++) m_prio[g][i] = reg_wdata[2*(i-16) +: 2];
        default: ;
      endcase
    end
    for (int k = 0; k < NG; k++) m_pend[k] = m_pend[k] | src_evt[k*SN +: SN];
  endfunction

  // One clock: outputs after this edge reflect the state before it (R9)
  task automatic tick();
    @(posedge clk);
    model_out(e_req, e_lvl, e_vec);
    model_step();
    @(negedge clk);
    chk("R8 R9 req", {31'd0, irq_req}, {31'd0, e_req});
    chk("R6 R7 R9 level", {29'd0, irq_level}, {29'd0, e_lvl});
    chk("R5 R7 R9 vector", {15'd0, irq_vector}, {15'd0, e_vec});
    reg_wr = 0; src_evt = '0;
  endtask

  task automatic wr(int g, int s, logic [31:0] d);
    reg_wr = 1; reg_addr = {g[1:0], s[2:0]}; reg_wdata = d;
    tick();
  endtask

  task automatic rd(int g, int s, logic [31:0] exp, string tag);
    reg_addr = {g[1:0], s[2:0]};
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic evt(int g, int b);
    src_evt[g*SN + b] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    for (int g = 0; g < NG; g++) begin
      m_pend[g] = '0; m_en[g] = '0; m_vec[g] = '0;
      for (int i = 0; i < SN; i++) m_prio[g][i] = '0;
    end
    rst_n = 0; src_evt = '0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 req", {31'd0, irq_req}, 32'd0);
    chk("R1 level", {29'd0, irq_level}, 32'd0);
    rd(0, 0, 32'd0, "R1 pending");
    rd(3, 3, 32'd0, "R1 vector reg");

    // R10 pending without enable, R2 sticky
    evt(0, 29); tick(); tick();
    chk("R10 no request", {31'd0, irq_req}, 32'd0);
    rd(0, 0, 32'h2000_0000, "R2 sticky pending");
    wr(0, 3, 32'h0000_0500);
    wr(0, 1, 32'hffff_ffff);
    rd(0, 1, 32'h7fff_ffff, "R3 R4 enable set all");
    tick();
    chk("R10 R5 vector", {15'd0, irq_vector}, 32'h500);
    chk("R6 level one", {29'd0, irq_level}, 32'd1);

    // R5 another bit, same vector
    evt(0, 0); tick(); tick();
    chk("R5 same group vector", {15'd0, irq_vector}, 32'h500);

    // R6 max priority: source 29 code 2
    wr(0, 5, 32'h2 << 26); tick();
    chk("R6 max code level", {29'd0, irq_level}, 32'd3);
    rd(0, 5, 32'h2 << 26, "R6 hi priority layout");

    // R7 tie goes to lower group
    wr(2, 3, 32'h1abcd); wr(2, 1, 32'h20); wr(2, 4, 32'h2 << 10);
    evt(2, 5); tick(); tick();
    chk("R7 tie lower group", {15'd0, irq_vector}, 32'h500);
    wr(2, 4, 32'h3 << 10);
    chk("R9 old winner held", {15'd0, irq_vector}, 32'h500);
    tick();
    chk("R7 higher wins", {15'd0, irq_vector}, 32'h1abcd);
    chk("R7 higher level", {29'd0, irq_level}, 32'd4);

    // R2 event and clear in the same clock
    evt(2, 5); wr(2, 0, 32'h20); tick();
    rd(2, 0, 32'h20, "R2 set beats clear");
    wr(2, 0, 32'h20); tick();
    rd(2, 0, 32'h0, "R2 cleared");
    chk("R2 winner reverts", {15'd0, irq_vector}, 32'h500);

    // R3 / R8 disable everything
    wr(0, 2, 32'hffff_ffff); tick();
    rd(0, 2, 32'h0, "R3 enable cleared");
    chk("R8 idle req", {31'd0, irq_req}, 32'd0);
    chk("R8 idle vector", {15'd0, irq_vector}, 32'd0);
    wr(1, 1, 32'h8000_0000);
    rd(1, 1, 32'h0, "R4 bit31 enable");
    rd(0, 0, 32'h2000_0001, "R11 R4 pending group 0");

    // Random phase
    for (int n = 0; n < 600; n++) begin
      for (int g = 0; g < NG; g++)
        if ($urandom_range(0, 3) == 0)
          src_evt[g*SN +: SN] = SN'($urandom & $urandom & $urandom);
      if ($urandom_range(0, 2) == 0) begin
        reg_wr = 1;
        reg_addr = {2'($urandom_range(0, 3)), 3'($urandom_range(0, 5))};
        reg_wdata = $urandom;
      end
      tick();
    end
    repeat (2) tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule